// File: doc/BRIEF.md
# Low-Power Stop Mode Sequencer

This block decides what a small microcontroller does when its CPU decodes a stop instruction. The CPU signals the decode with a one-cycle `stop_req` strobe. In the cycle it accepts the strobe, the block samples five configuration bits, plus the bit that picks what a supply-drop detection does. It then either enters one of four low-power modes or raises an illegal-opcode reset pulse. While the block is stopped, it drives plain status pins to the regulator, the debug clock tree and two analog consumers. These pins state whether each one may keep running.

A stopped block returns to run on an enabled external reset, a supply-drop event, or any enabled wake interrupt. On the cycle it returns, it reports a wake cause, which tells the CPU whether to fetch the reset vector or an interrupt vector. For an interrupt it also reports the source index. Every pin is a plain control or status level or strobe. No data moves through the block, so there is no valid/ready interface and no back-pressure.

Top module: `stop_mode_ctrl`

## Requirements
- R1: After reset, `mode_status` is 5'b00001 (run), `wake_cause` is 2'b00, and `illegal_rst`, `reg_lowpwr`, `dbg_clk_hold`, `conv_stop_ok` and `cmp_ref_stop_ok` are all 0.
- R2: A `stop_req` in run with `cfg_stop_en`=0 makes `illegal_rst` high for exactly one cycle, starting one clock after the request. The mode stays run.
- R3: With `cfg_stop_en`=1 and `cfg_dbg_en`=1, whatever the other bits are, the mode becomes debug-stop (bit 3, 5'b01000) one clock after the request. In this mode `dbg_clk_hold`=1 and `reg_lowpwr`=0.
- R4: With stop enabled, debug off, and both `cfg_vdet_en` and `cfg_vdet_stop_en` at 1, the mode becomes regulator-on stop (bit 2, 5'b00100) with `reg_lowpwr`=0.
- R5: With stop enabled, debug off and either voltage-detect bit at 0, `cfg_pdown_sel`=0 gives shallow stop (bit 1, 5'b00010) and 1 gives deep stop (bit 4, 5'b10000). Both set `reg_lowpwr`=1. Exactly one bit of `mode_status` is ever set.
- R6: Configuration is sampled only when a request is accepted. Changes to any `cfg_*` input while stopped leave `mode_status` and the status pins unchanged.
- R7: A `stop_req` while stopped is ignored: the mode is unchanged and `illegal_rst` stays 0.
- R8: While stopped, `ext_rst` with `ext_rst_en`=1 returns the block to run with `wake_cause`=2'b01 (reset vector). With `ext_rst_en`=0 it has no effect.
- R9: While stopped, any `wake_irq[i]` with `wake_irq_en[i]`=1 returns the block to run with `wake_cause`=2'b10 and `wake_src` set to the lowest such index. Masked lines have no effect. Source indices: 0 timer, 1 voltage detect, 2 comparator, 3 converter, 4 serial receive, 5 pin.
- R10: If an enabled reset and an enabled interrupt arrive in the same cycle, `wake_cause` is 2'b01.
- R11: `wake_cause` is non-zero for exactly one cycle, the first cycle back in run. It is 2'b00 otherwise, and `wake_src` is 0 unless the cause is 2'b10.
- R12: When both voltage-detect bits were 1 at entry, `vdet_low` while stopped causes a reset wake if the sampled `cfg_vdet_act_rst` is 1. If it is 0, it causes an interrupt wake on source 1, gated by `wake_irq_en[1]`. When either bit was 0 at entry, `vdet_low` is ignored.
- R13: `conv_stop_ok` equals `conv_want`, and `cmp_ref_stop_ok` equals `cmp_ref_want`, only while stopped in a shallow mode entered with both voltage-detect bits at 1. Otherwise both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Decoded stop instruction strobe |
| cfg_stop_en | input | 1 | Stop allowed |
| cfg_dbg_en | input | 1 | Debug mode enabled |
| cfg_vdet_en | input | 1 | Voltage detect enabled |
| cfg_vdet_stop_en | input | 1 | Voltage detect kept on in stop |
| cfg_pdown_sel | input | 1 | Picks deep (1) or shallow (0) stop |
| cfg_vdet_act_rst | input | 1 | Supply drop acts as reset (1) or interrupt (0) |
| ext_rst | input | 1 | External reset pin event |
| ext_rst_en | input | 1 | External reset pin enabled |
| wake_irq | input | NSRC | Wake interrupt requests |
| wake_irq_en | input | NSRC | Per-source wake enables |
| vdet_low | input | 1 | Supply below detect threshold |
| conv_want | input | 1 | Converter asks to run in stop |
| cmp_ref_want | input | 1 | Comparator asks for internal reference in stop |
| mode_status | output | 5 | One-hot mode: run, shallow, regulator-on, debug, deep |
| illegal_rst | output | 1 | Illegal-opcode reset pulse |
| reg_lowpwr | output | 1 | Regulator may drop to standby |
| dbg_clk_hold | output | 1 | Debug clocks kept running |
| conv_stop_ok | output | 1 | Converter may run in stop |
| cmp_ref_stop_ok | output | 1 | Comparator reference may run in stop |
| wake_cause | output | 2 | 00 none, 01 reset vector, 10 interrupt vector |
| wake_src | output | $clog2(NSRC) | Index of the waking interrupt |

## Verification
Every registered result (`mode_status`, `illegal_rst`, `wake_cause`, `wake_src`) is due one clock after its stimulus is sampled. The derived status pins follow `mode_status` in the same cycle. The bench drives each stimulus on a falling edge and checks it on the next falling edge, so exactly one rising edge lies between them. It then checks again one edge later, which confirms that the pulses and wake causes last only one cycle. Checks that something is ignored wait two further edges and confirm that the mode and status pins are unchanged.

// File: rtl/stop_pkg.sv
package stop_pkg;
  localparam int NMODE  = 5;
  localparam int M_RUN  = 0;
  localparam int M_SHAL = 1;
  localparam int M_REG  = 2;
  localparam int M_DBG  = 3;
  localparam int M_DEEP = 4;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_RST  = 2'b01,
    CAUSE_IRQ  = 2'b10
  } cause_e;
endpackage

// File: rtl/stop_mode_decode.sv
module stop_mode_decode
  import stop_pkg::*;
(
  input  logic             stop_en,
  input  logic             dbg_en,
  input  logic             vdet_en,
  input  logic             vdet_stop_en,
  input  logic             pdown_sel,
  output logic             illegal,
  output logic [NMODE-1:0] target
);
  // Fixed priority: disabled stop, then debug, then live voltage detect, then power-down select
  always_comb begin
    illegal = 1'b0;
    target  = '0;
    if (!stop_en)                   illegal          = 1'b1;
    else if (dbg_en)                target[M_DBG]  = 1'b1;
    else if (vdet_en && vdet_stop_en) target[M_REG] = 1'b1;
    else if (pdown_sel)             target[M_DEEP] = 1'b1;
    else                            target[M_SHAL] = 1'b1;
  end

  always_comb begin
    a_r5_decode_onehot: assert (illegal || $countones(target) == 1);
  end
endmodule

// File: rtl/stop_wake_arb.sv
module stop_wake_arb #(
  parameter int NSRC     = 6,
  parameter int VDET_IDX = 1,
  localparam int IDXW    = $clog2(NSRC)
) (
  input  logic            stopped,
  input  logic            ext_rst,
  input  logic            ext_rst_en,
  input  logic [NSRC-1:0] irq,
  input  logic [NSRC-1:0] irq_en,
  input  logic            vdet_low,
  input  logic            vdet_live,
  input  logic            vdet_act_rst,
  output logic            wake_rst,
  output logic            wake_irq,
  output logic [IDXW-1:0] src
);
  logic [NSRC-1:0] vdet_vec;
  logic [NSRC-1:0] eff;
  logic            vdet_rst;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_vdet
      if (g == VDET_IDX) begin : g_hit
        assign vdet_vec[g] = vdet_live & ~vdet_act_rst & vdet_low;
      end else begin : g_miss
        assign vdet_vec[g] = 1'b0;
      end
    end
  endgenerate

  assign eff      = (irq | vdet_vec) & irq_en;
  assign vdet_rst = vdet_live & vdet_act_rst & vdet_low;
  assign wake_rst = stopped & ((ext_rst & ext_rst_en) | vdet_rst);
  assign wake_irq = stopped & (|eff) & ~wake_rst;

  // Lowest index wins
  always_comb begin
    src = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (eff[i]) src = IDXW'(i);
    end
  end

  always_comb begin
    a_r10_excl: assert (!(wake_rst && wake_irq));
  end
endmodule

// File: rtl/stop_mode_ctrl.sv
module stop_mode_ctrl
  import stop_pkg::*;
#(
  parameter int NSRC     = 6,
  parameter int VDET_IDX = 1,
  localparam int IDXW    = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             cfg_stop_en,
  input  logic             cfg_dbg_en,
  input  logic             cfg_vdet_en,
  input  logic             cfg_vdet_stop_en,
  input  logic             cfg_pdown_sel,
  input  logic             cfg_vdet_act_rst,
  input  logic             ext_rst,
  input  logic             ext_rst_en,
  input  logic [NSRC-1:0]  wake_irq,
  input  logic [NSRC-1:0]  wake_irq_en,
  input  logic             vdet_low,
  input  logic             conv_want,
  input  logic             cmp_ref_want,
  output logic [NMODE-1:0] mode_status,
  output logic             illegal_rst,
  output logic             reg_lowpwr,
  output logic             dbg_clk_hold,
  output logic             conv_stop_ok,
  output logic             cmp_ref_stop_ok,
  output logic [1:0]       wake_cause,
  output logic [IDXW-1:0]  wake_src
);
  logic [NMODE-1:0] mode_q;
  logic             illegal_q;
  cause_e           cause_q;
  logic [IDXW-1:0]  src_q;
  logic             lat_vdet_live;
  logic             lat_act_rst;

  logic             dec_illegal;
  logic [NMODE-1:0] dec_target;
  logic             w_rst, w_irq;
  logic [IDXW-1:0]  w_src;
  logic             running, shallow_any;

  assign running     = mode_q[M_RUN];
  assign shallow_any = mode_q[M_SHAL] | mode_q[M_REG] | mode_q[M_DBG];

  stop_mode_decode u_dec (
    .stop_en      (cfg_stop_en),
    .dbg_en       (cfg_dbg_en),
    .vdet_en      (cfg_vdet_en),
    .vdet_stop_en (cfg_vdet_stop_en),
    .pdown_sel    (cfg_pdown_sel),
    .illegal      (dec_illegal),
    .target       (dec_target)
  );

  stop_wake_arb #(.NSRC(NSRC), .VDET_IDX(VDET_IDX)) u_wake (
    .stopped      (~running),
    .ext_rst      (ext_rst),
    .ext_rst_en   (ext_rst_en),
    .irq          (wake_irq),
    .irq_en       (wake_irq_en),
    .vdet_low     (vdet_low),
    .vdet_live    (lat_vdet_live),
    .vdet_act_rst (lat_act_rst),
    .wake_rst     (w_rst),
    .wake_irq     (w_irq),
    .src          (w_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q        <= NMODE'(1) << M_RUN;
      illegal_q     <= 1'b0;
      cause_q       <= CAUSE_NONE;
      src_q         <= '0;
      lat_vdet_live <= 1'b0;
      lat_act_rst   <= 1'b0;
    end else begin
      illegal_q <= 1'b0;
      cause_q   <= CAUSE_NONE;
      src_q     <= '0;
      if (running) begin
        if (stop_req) begin
          if (dec_illegal) begin
            illegal_q <= 1'b1;
          end else begin
            mode_q        <= dec_target;
            lat_vdet_live <= cfg_vdet_en & cfg_vdet_stop_en;
            lat_act_rst   <= cfg_vdet_act_rst;
          end
        end
      end else if (w_rst) begin
        mode_q  <= NMODE'(1) << M_RUN;
        cause_q <= CAUSE_RST;
      end else if (w_irq) begin
        mode_q  <= NMODE'(1) << M_RUN;
        cause_q <= CAUSE_IRQ;
        src_q   <= w_src;
      end
    end
  end

  assign mode_status     = mode_q;
  assign illegal_rst     = illegal_q;
  assign wake_cause      = cause_q;
  assign wake_src        = src_q;
  assign reg_lowpwr      = mode_q[M_SHAL] | mode_q[M_DEEP];
  assign dbg_clk_hold    = mode_q[M_DBG];
  assign conv_stop_ok    = conv_want & lat_vdet_live & shallow_any;
  assign cmp_ref_stop_ok = cmp_ref_want & lat_vdet_live & shallow_any;

  a_r5_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_status) == 1);
  a_r2_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    running && stop_req && !cfg_stop_en |=> illegal_rst && mode_status[M_RUN]);
  a_r3_debug: assert property (@(posedge clk) disable iff (!rst_n)
    running && stop_req && cfg_stop_en && cfg_dbg_en |=> mode_status[M_DBG] && dbg_clk_hold);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !w_rst && !w_irq |=> $stable(mode_status));
  a_r8_reset_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !running && ext_rst && ext_rst_en |=> wake_cause == CAUSE_RST && mode_status[M_RUN]);
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cause != CAUSE_NONE |=> wake_cause == CAUSE_NONE);
  a_r11_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cause != CAUSE_NONE |-> mode_status[M_RUN]);
  a_r13_gate: assert property (@(posedge clk) disable iff (!rst_n)
    conv_stop_ok |-> shallow_any && !mode_status[M_SHAL]);
endmodule

// File: tb/stop_mode_ctrl_test.sv
module stop_mode_ctrl_test;
  localparam int NSRC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 0, cfg_stop_en = 0, cfg_dbg_en = 0, cfg_vdet_en = 0;
  logic cfg_vdet_stop_en = 0, cfg_pdown_sel = 0, cfg_vdet_act_rst = 0;
  logic ext_rst = 0, ext_rst_en = 0, vdet_low = 0, conv_want = 0, cmp_ref_want = 0;
  logic [NSRC-1:0] wake_irq = '0, wake_irq_en = '0;
  logic [4:0] mode_status;
  logic illegal_rst, reg_lowpwr, dbg_clk_hold, conv_stop_ok, cmp_ref_stop_ok;
  logic [1:0] wake_cause;
  logic [2:0] wake_src;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stop_mode_ctrl #(.NSRC(NSRC)) uut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(logic se, logic de, logic ve, logic vs, logic pd, logic ar);
    cfg_stop_en = se; cfg_dbg_en = de; cfg_vdet_en = ve;
    cfg_vdet_stop_en = vs; cfg_pdown_sel = pd; cfg_vdet_act_rst = ar;
  endtask

  task automatic request_stop();
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
  endtask

  task automatic t_reset();
    chk("R1", "mode", mode_status, 5'b00001);
    chk("R1", "cause", wake_cause, 2'b00);
    chk("R1", "outs", {illegal_rst, reg_lowpwr, dbg_clk_hold, conv_stop_ok, cmp_ref_stop_ok}, 0);
  endtask

  task automatic t_illegal();
    set_cfg(0, 1, 1, 1, 1, 0);
    request_stop();
    chk("R2", "illegal pulse", illegal_rst, 1);
    chk("R2", "mode run", mode_status, 5'b00001);
    @(negedge clk);
    chk("R2", "pulse ends", illegal_rst, 0);
  endtask

  task automatic t_debug();
    set_cfg(1, 1, 0, 0, 1, 0);
    request_stop();
    chk("R3", "mode", mode_status, 5'b01000);
    chk("R3", "dbg clk/lowpwr", {dbg_clk_hold, reg_lowpwr}, 2'b10);
    ext_rst = 1; ext_rst_en = 1;
    @(negedge clk);
    ext_rst = 0;
    chk("R8", "reset cause", wake_cause, 2'b01);
    chk("R8", "back to run", mode_status, 5'b00001);
    @(negedge clk);
    chk("R11", "cause one cycle", wake_cause, 2'b00);
    ext_rst_en = 0;
  endtask

  task automatic t_reg_on();
    set_cfg(1, 0, 1, 1, 1, 0);
    request_stop();
    chk("R4", "mode", mode_status, 5'b00100);
    chk("R4", "lowpwr", reg_lowpwr, 0);
    set_cfg(0, 1, 0, 0, 0, 1);
    repeat (2) @(negedge clk);
    chk("R6", "mode held", mode_status, 5'b00100);
    chk("R6", "outs held", {reg_lowpwr, dbg_clk_hold}, 2'b00);
    request_stop();
    @(negedge clk);
    chk("R7", "req ignored", {illegal_rst, mode_status}, 6'b000100);
    conv_want = 1; cmp_ref_want = 1;
    #1;
    chk("R13", "conv/cmp ok", {conv_stop_ok, cmp_ref_stop_ok}, 2'b11);
    conv_want = 0; cmp_ref_want = 0;
    wake_irq_en = 6'b101000; wake_irq = 6'b101000;
    @(negedge clk);
    wake_irq = 0;
    chk("R9", "irq cause", wake_cause, 2'b10);
    chk("R9", "lowest src", wake_src, 3);
    @(negedge clk);
    chk("R11", "src cleared", {wake_cause, wake_src}, 0);
  endtask

  task automatic t_shallow();
    set_cfg(1, 0, 1, 0, 0, 0);
    request_stop();
    chk("R5", "shallow", mode_status, 5'b00010);
    chk("R5", "lowpwr", reg_lowpwr, 1);
    conv_want = 1;
    #1;
    chk("R13", "conv blocked", conv_stop_ok, 0);
    conv_want = 0;
    wake_irq_en = 6'b000001; wake_irq = 6'b000100;
    ext_rst = 1; ext_rst_en = 0;
    repeat (2) @(negedge clk);
    chk("R9", "masked ignored", mode_status, 5'b00010);
    chk("R8", "disabled reset ignored", wake_cause, 2'b00);
    wake_irq = 6'b000001; ext_rst_en = 1;
    @(negedge clk);
    wake_irq = 0; ext_rst = 0; ext_rst_en = 0;
    chk("R10", "reset wins", wake_cause, 2'b01);
  endtask

  task automatic t_deep();
    set_cfg(1, 0, 0, 1, 1, 0);
    request_stop();
    chk("R5", "deep", mode_status, 5'b10000);
    wake_irq_en = 6'b111111; wake_irq = 6'b100000;
    @(negedge clk);
    wake_irq = 0;
    chk("R9", "deep irq wake", {wake_cause, wake_src}, {2'b10, 3'd5});
  endtask

  task automatic t_vdet();
    set_cfg(1, 0, 1, 1, 0, 1);
    request_stop();
    vdet_low = 1;
    @(negedge clk);
    vdet_low = 0;
    chk("R12", "vdet reset", wake_cause, 2'b01);
    set_cfg(1, 0, 1, 1, 0, 0);
    wake_irq_en = 6'b000010;
    request_stop();
    vdet_low = 1;
    @(negedge clk);
    vdet_low = 0;
    chk("R12", "vdet irq", {wake_cause, wake_src}, {2'b10, 3'd1});
    set_cfg(1, 0, 0, 1, 0, 0);
    request_stop();
    vdet_low = 1;
    repeat (2) @(negedge clk);
    vdet_low = 0;
    chk("R12", "vdet not live", {wake_cause, mode_status}, {2'b00, 5'b00010});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_illegal();
    t_debug();
    t_reg_on();
    t_shallow();
    t_deep();
    t_vdet();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule